// File: doc/BRIEF.md
# Integer ALU with Condition Codes and Branch Resolution

This block is the arithmetic and logic stage of a simple integer pipeline. Each cycle it takes a first operand and a second operand, which is either a register value or an immediate. It produces a combinational result for one of eleven operations: add, subtract, six bitwise operations and three shifts. When the flag-write input is high, the clock edge also stores four condition flags in a register: negative, zero, overflow and carry/borrow.

A separate 4-bit branch selector picks one test on the stored flags. The tests cover signed compares, unsigned compares, single-flag checks, always and never. The taken output depends only on the stored flags. A branch therefore sees the flags left by the most recent flag-writing operation, and never the flags that operation is producing in the same cycle.

Top module: `alu_cc_core`

## Requirements
- R1: Opcode 0 (add) gives `a + b` mod 2^W. Its carry flag is the carry out of the top bit, and its overflow flag is set when the signed sum falls outside the signed W-bit range.
- R2: Opcode 1 (subtract) gives `a - b` mod 2^W, formed as `a + ~b + 1`. Its carry flag is set when there is no carry out of the top bit (a borrow, which means `a < b` unsigned). Its overflow flag is set when the signs of `a` and `b` differ and the result sign equals the sign of `b`. For example, the most negative value minus 2 overflows.
- R3: Opcodes 2..7 give AND, AND-NOT (`a & ~b`), OR, OR-NOT (`a | ~b`), XOR and XNOR. For these opcodes the overflow and carry flags are written as 0. Opcodes 11..15 give a zero result.
- R4: Opcode 8 shifts left and opcode 9 shifts right, both filling with zeros. Opcode 10 shifts right and fills with copies of the sign bit. The shift count is the low log2(W) bits of the second operand.
- R5: The second operand is the immediate input when the immediate-select input is 1, and the register input otherwise.
- R6: The written zero flag is 1 exactly when every result bit is 0. The written negative flag equals the result's top bit.
- R7: The flags output {N,Z,V,C} (bits 3..0) changes only on a rising clock edge where flag-write is 1. In that case it takes the flags of that cycle's operation. Otherwise the flags keep their value.
- R8: A synchronous active-high reset clears all four flags.
- R9: The signed branch codes are 1 (equal: Z), 9 (not equal: !Z), 3 (less: N^V), 2 (less or equal: Z|(N^V)), 11 (greater or equal: !(N^V)) and 10 (greater: !(Z|(N^V))).
- R10: The unsigned branch codes are 5 (lower, also carry set: C), 4 (lower or same: Z|C), 13 (higher or same, also carry clear: !C) and 12 (higher: !Z&!C).
- R11: The single-flag branch codes are 6 (negative: N), 14 (positive: !N), 7 (overflow set: V) and 15 (overflow clear: !V). Code 0 is never taken and code 8 is always taken.
- R12: The taken output is combinational from the stored flags only. A flag write in the same cycle does not affect it until after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 4 | Operation code |
| set_cc_i | input | 1 | Write the flags at the next edge |
| use_imm_i | input | 1 | Select the immediate as second operand |
| rs1_i | input | W | First operand |
| rs2_i | input | W | Register second operand |
| imm_i | input | W | Immediate second operand |
| cond_i | input | 4 | Branch test selector |
| result_o | output | W | Operation result |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |
| taken_o | output | 1 | Branch test outcome on the stored flags |

## Verification
A flag-writing compare and a branch test can occur in the same cycle. The branch must then resolve on the flags from before that compare. The bench first leaves the zero flag set with an equal compare. It then drives an unequal compare with flag-write high while the selector asks for "equal". Just before the edge, taken must still be 1. After the edge it must read 0, and the "less" test must reflect the new compare.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_ANDN = 4'd3,
        OP_OR   = 4'd4,
        OP_ORN  = 4'd5,
        OP_XOR  = 4'd6,
        OP_XNOR = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10
    } alu_op_e;

    // Bit 3 inverts the base test chosen by bits 2..0.
    typedef enum logic [3:0] {
        BR_NEVER  = 4'd0,
        BR_EQ     = 4'd1,
        BR_LE     = 4'd2,
        BR_LT     = 4'd3,
        BR_LEU    = 4'd4,
        BR_LTU    = 4'd5,
        BR_NEG    = 4'd6,
        BR_VS     = 4'd7,
        BR_ALWAYS = 4'd8,
        BR_NE     = 4'd9,
        BR_GT     = 4'd10,
        BR_GE     = 4'd11,
        BR_GTU    = 4'd12,
        BR_GEU    = 4'd13,
        BR_POS    = 4'd14,
        BR_VC     = 4'd15
    } br_cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_cc_opsel.sv
module alu_cc_opsel #(
    parameter int W = 16
) (
    input  logic         use_imm,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] op2
);
    always_comb op2 = use_imm ? imm_val : reg_val;
endmodule

// File: rtl/alu_cc_shift.sv
module alu_cc_shift #(
    parameter int W   = 16,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   dout
);
    logic fill;
    logic [W-1:0] stg [0:SHW];

    always_comb fill = arith & din[W-1];
    assign stg[0] = din;

    // One stage per count bit; stage s moves by 2**s.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] moved;
        always_comb begin
            if (left) moved = {stg[s][W-1-SH:0], {SH{1'b0}}};
            else      moved = {{SH{fill}}, stg[s][W-1:SH]};
        end
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign dout = stg[SHW];
endmodule

// File: rtl/alu_cc_exec.sv
module alu_cc_exec
    import alu_cc_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = $clog2(W)
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output cc_t          cc
);
    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [W-1:0] sh_out;
    logic         v_add, v_sub;

    always_comb begin
        is_sub = (op == OP_SUB);
        b_eff  = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    end

    alu_cc_shift #(.W(W), .SHW(SHW)) u_shift (
        .din   (a),
        .amt   (b[SHW-1:0]),
        .left  (op == OP_SLL),
        .arith (op == OP_SRA),
        .dout  (sh_out)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:         res = sum[W-1:0];
            OP_AND:                 res = a & b;
            OP_ANDN:                res = a & ~b;
            OP_OR:                  res = a | b;
            OP_ORN:                 res = a | ~b;
            OP_XOR:                 res = a ^ b;
            OP_XNOR:                res = ~(a ^ b);
            OP_SLL, OP_SRL, OP_SRA: res = sh_out;
            default:                res = '0;
        endcase
    end

    always_comb begin
        v_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        v_sub = (a[W-1] != b[W-1]) && (sum[W-1] == b[W-1]);
        cc.n  = res[W-1];
        cc.z  = ~|res;
        if (op_is_arith(op)) begin
            cc.v = is_sub ? v_sub : v_add;
            cc.c = is_sub ? ~sum[W] : sum[W];
        end else begin
            cc.v = 1'b0;
            cc.c = 1'b0;
        end
    end
endmodule

// File: rtl/alu_cc_ccreg.sv
module alu_cc_ccreg
    import alu_cc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cc_t  d,
    output cc_t  q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= CC_RESET;
        else if (we) q <= d;
    end
endmodule

// File: rtl/alu_cc_branch.sv
module alu_cc_branch
    import alu_cc_pkg::*;
(
    input  cc_t        cc,
    input  logic [3:0] cond,
    output logic       taken
);
    logic lt_s, base;

    always_comb begin
        lt_s = cc.n ^ cc.v;
        unique case (cond[2:0])
            3'd0: base = 1'b0;
            3'd1: base = cc.z;
            3'd2: base = cc.z | lt_s;
            3'd3: base = lt_s;
            3'd4: base = cc.z | cc.c;
            3'd5: base = cc.c;
            3'd6: base = cc.n;
            default: base = cc.v;
        endcase
        taken = base ^ cond[3];
    end
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic         set_cc_i,
    input  logic         use_imm_i,
    input  logic [W-1:0] rs1_i,
    input  logic [W-1:0] rs2_i,
    input  logic [W-1:0] imm_i,
    input  logic [3:0]   cond_i,
    output logic [W-1:0] result_o,
    output logic [3:0]   flags_o,
    output logic         taken_o
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] op2;
    cc_t          cc_next;
    cc_t          cc_q;

    alu_cc_opsel #(.W(W)) u_opsel (
        .use_imm (use_imm_i),
        .reg_val (rs2_i),
        .imm_val (imm_i),
        .op2     (op2)
    );

    alu_cc_exec #(.W(W), .SHW(SHW)) u_exec (
        .op  (alu_op_e'(op_i)),
        .a   (rs1_i),
        .b   (op2),
        .res (result_o),
        .cc  (cc_next)
    );

    alu_cc_ccreg u_ccreg (
        .clk (clk),
        .rst (rst),
        .we  (set_cc_i),
        .d   (cc_next),
        .q   (cc_q)
    );

    alu_cc_branch u_branch (
        .cc    (cc_q),
        .cond  (cond_i),
        .taken (taken_o)
    );

    assign flags_o = cc_q;
endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_i,
    input logic         set_cc_i,
    input logic         use_imm_i,
    input logic [W-1:0] rs1_i,
    input logic [W-1:0] rs2_i,
    input logic [W-1:0] imm_i,
    input logic [3:0]   cond_i,
    input logic [W-1:0] result_o,
    input logic [3:0]   flags_o,
    input logic         taken_o,
    input logic [3:0]   cc_next
);
    logic [W:0] chk_sum;
    always_comb chk_sum = {1'b0, rs1_i} + {1'b0, (use_imm_i ? imm_i : rs2_i)};

    a_r8_reset_clear: assert property (@(posedge clk) rst |=> flags_o == 4'd0);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !set_cc_i |=> flags_o == $past(flags_o));

    a_r7_write: assert property (@(posedge clk) disable iff (rst)
        set_cc_i |=> flags_o == $past(cc_next));

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (set_cc_i && result_o == '0) |=> flags_o[2]);

    a_r6_negative: assert property (@(posedge clk) disable iff (rst)
        (set_cc_i && result_o[W-1]) |=> flags_o[3]);

    a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
        (set_cc_i && op_i == 4'd0) |=> flags_o[0] == $past(chk_sum[W]));

    a_r3_logic_clear: assert property (@(posedge clk) disable iff (rst)
        (set_cc_i && op_i >= 4'd2 && op_i <= 4'd7) |=> flags_o[1:0] == 2'b00);

    a_r11_never: assert property (@(posedge clk) disable iff (rst)
        cond_i == 4'd0 |-> !taken_o);

    a_r11_always: assert property (@(posedge clk) disable iff (rst)
        cond_i == 4'd8 |-> taken_o);

    a_r9_less: assert property (@(posedge clk) disable iff (rst)
        cond_i == 4'd3 |-> taken_o == (flags_o[3] ^ flags_o[1]));

    a_r10_lower: assert property (@(posedge clk) disable iff (rst)
        cond_i == 4'd5 |-> taken_o == flags_o[0]);
endmodule

bind alu_cc_core alu_cc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .set_cc_i  (set_cc_i),
    .use_imm_i (use_imm_i),
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .imm_i     (imm_i),
    .cond_i    (cond_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .taken_o   (taken_o),
    .cc_next   (cc_next)
);

// File: tb/sim_alu_cc_core.sv
`timescale 1ns/1ps
module sim_alu_cc_core;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_i = '0;
    logic         set_cc_i = 1'b0;
    logic         use_imm_i = 1'b0;
    logic [W-1:0] rs1_i = '0;
    logic [W-1:0] rs2_i = '0;
    logic [W-1:0] imm_i = '0;
    logic [3:0]   cond_i = '0;
    logic [W-1:0] result_o;
    logic [3:0]   flags_o;
    logic         taken_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_cc_core #(.W(W)) u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .set_cc_i(set_cc_i),
        .use_imm_i(use_imm_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
        .cond_i(cond_i), .result_o(result_o), .flags_o(flags_o), .taken_o(taken_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation after a falling edge; result settles 1 ns later.
    task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic imm, input logic setcc);
        @(negedge clk);
        op_i = op; rs1_i = a; set_cc_i = setcc; use_imm_i = imm;
        if (imm) begin imm_i = b; rs2_i = ~b; end
        else     begin rs2_i = b; imm_i = ~b; end
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [3:0] sub_flags(input logic [W-1:0] m, input logic [W-1:0] s);
        int dm;
        logic [W-1:0] d;
        logic n, z, v, c;
        dm = int'($signed(m)) - int'($signed(s));
        d  = m - s;
        n  = d[W-1];
        z  = (d == '0);
        v  = (dm > 32767) || (dm < -32768);
        c  = (m < s);
        return {n, z, v, c};
    endfunction

    function automatic logic exp_taken(input logic [3:0] cond, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (cond)
            4'd0:  return 1'b0;
            4'd8:  return 1'b1;
            4'd1:  return z;
            4'd9:  return !z;
            4'd3:  return n != v;
            4'd2:  return z || (n != v);
            4'd11: return n == v;
            4'd10: return !z && (n == v);
            4'd5:  return c;
            4'd4:  return z || c;
            4'd13: return !c;
            4'd12: return !z && !c;
            4'd6:  return n;
            4'd14: return !n;
            4'd7:  return v;
            default: return !v;
        endcase
    endfunction

    task automatic t_reset();
        step();
        chk("R8 flags after reset", 32'(flags_o), 32'h0);
        cond_i = 4'd0; #1;
        chk("R11 never", 32'(taken_o), 32'h0);
        cond_i = 4'd8; #1;
        chk("R11 always", 32'(taken_o), 32'h1);
    endtask

    task automatic t_add();
        issue(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
        chk("R1 add wrap result", 32'(result_o), 32'h0);
        step();
        chk("R1/R6 add carry zero flags", 32'(flags_o), 32'b0101);
        issue(4'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b1);
        chk("R1/R5 add imm result", 32'(result_o), 32'h8000);
        step();
        chk("R1/R6 add signed overflow flags", 32'(flags_o), 32'b1010);
    endtask

    task automatic t_sub();
        issue(4'd1, 16'd12, 16'd9, 1'b0, 1'b1);
        chk("R2 sub result", 32'(result_o), 32'd3);
        step();
        chk("R2 sub no borrow flags", 32'(flags_o), 32'b0000);
        issue(4'd1, 16'd9, 16'd12, 1'b0, 1'b1);
        chk("R2 sub negative result", 32'(result_o), 32'hFFFD);
        step();
        chk("R2 sub borrow flags", 32'(flags_o), 32'b1001);
        issue(4'd1, 16'h8000, 16'd2, 1'b1, 1'b1);
        chk("R2 most negative minus 2 result", 32'(result_o), 32'h7FFE);
        step();
        chk("R2 most negative minus 2 overflow", 32'(flags_o), 32'b0010);
    endtask

    task automatic t_logic();
        logic [W-1:0] a, b;
        logic [W-1:0] exp [0:5];
        a = 16'hF0F0; b = 16'hFF00;
        exp[0] = a & b; exp[1] = a & ~b; exp[2] = a | b;
        exp[3] = a | ~b; exp[4] = a ^ b; exp[5] = ~(a ^ b);
        for (int k = 0; k < 6; k++) begin
            issue(4'd0, 16'hFFFF, 16'h8000, 1'b0, 1'b1);
            step();
            chk("R1 setup V and C set", 32'(flags_o[1:0]), 32'b11);
            issue(4'(k + 2), a, b, 1'b0, 1'b1);
            chk("R3 logic result", 32'(result_o), 32'(exp[k]));
            step();
            chk("R3 logic flags", 32'(flags_o), 32'({exp[k][W-1], exp[k] == '0, 2'b00}));
        end
        issue(4'd3, 16'h1234, 16'hFFFF, 1'b0, 1'b1);
        step();
        chk("R6 logic zero result flags", 32'(flags_o), 32'b0100);
        issue(4'd12, 16'h1234, 16'h5678, 1'b0, 1'b0);
        chk("R3 reserved opcode zero", 32'(result_o), 32'h0);
    endtask

    task automatic t_shift();
        issue(4'd8, 16'h8421, 16'd4, 1'b1, 1'b0);
        chk("R4 shift left imm", 32'(result_o), 32'h4210);
        issue(4'd9, 16'h8421, 16'h0014, 1'b0, 1'b0);
        chk("R4/R5 logical right count low bits", 32'(result_o), 32'h0842);
        issue(4'd10, 16'h8421, 16'h0004, 1'b0, 1'b0);
        chk("R4 arith right sign fill", 32'(result_o), 32'hF842);
        issue(4'd10, 16'h8421, 16'd15, 1'b1, 1'b0);
        chk("R4 arith right max count", 32'(result_o), 32'hFFFF);
        issue(4'd10, 16'h4421, 16'd4, 1'b1, 1'b0);
        chk("R4 arith right positive", 32'(result_o), 32'h0442);
        issue(4'd8, 16'h8421, 16'h0010, 1'b0, 1'b0);
        chk("R4 count zero after masking", 32'(result_o), 32'h8421);
    endtask

    task automatic t_hold();
        issue(4'd1, 16'd1, 16'd2, 1'b0, 1'b1);
        step();
        chk("R7 flags written", 32'(flags_o), 32'b1001);
        issue(4'd1, 16'd5, 16'd5, 1'b0, 1'b0);
        step();
        step();
        chk("R7 flags held without write", 32'(flags_o), 32'b1001);
    endtask

    task automatic t_branch();
        logic [W-1:0] pm [0:5];
        logic [W-1:0] ps [0:5];
        logic [3:0] f;
        pm[0] = 16'd5;    ps[0] = 16'd5;
        pm[1] = 16'd3;    ps[1] = 16'd7;
        pm[2] = 16'd7;    ps[2] = 16'd3;
        pm[3] = 16'h8000; ps[3] = 16'd1;
        pm[4] = 16'd1;    ps[4] = 16'h8000;
        pm[5] = 16'hFFFF; ps[5] = 16'd0;
        for (int p = 0; p < 6; p++) begin
            f = sub_flags(pm[p], ps[p]);
            issue(4'd1, pm[p], ps[p], 1'b0, 1'b1);
            step();
            chk("R2 compare flags", 32'(flags_o), 32'(f));
            for (int c = 0; c < 16; c++) begin
                cond_i = 4'(c); #1;
                chk($sformatf("R9/R10/R11 branch code %0d pair %0d", c, p),
                    32'(taken_o), 32'(exp_taken(4'(c), f)));
            end
        end
    endtask

    task automatic t_same_cycle();
        issue(4'd1, 16'd5, 16'd5, 1'b0, 1'b1);
        step();
        cond_i = 4'd1;
        issue(4'd1, 16'd3, 16'd7, 1'b0, 1'b1);
        chk("R12 equal still taken before edge", 32'(taken_o), 32'h1);
        chk("R12 flags unchanged before edge", 32'(flags_o), 32'b0100);
        step();
        chk("R12 equal not taken after edge", 32'(taken_o), 32'h0);
        cond_i = 4'd3; #1;
        chk("R9 less after edge", 32'(taken_o), 32'h1);
        issue(4'd0, 16'd0, 16'd0, 1'b0, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R8 reset clears flags", 32'(flags_o), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_hold();
        t_branch();
        t_same_cycle();
        finish_run();
    end
endmodule